// File: doc/BRIEF.md
# SPI Memory Write-Protection Controller

This block is the command decoder and write-guard logic for a 2 KB serial memory that sits behind an SPI slave port in mode 0. Bytes arrive MSB first. The block recognises six one-byte opcodes: set the write-enable latch, clear it, read the status byte, write the status byte, read the array and write the array. It keeps an 8-bit status byte with three control fields and a write-enable latch. It also holds the byte array itself, a plain synchronous RAM. Each time a byte is about to be stored, whether in the status byte or in the array, the block decides whether the store is allowed.

Protection works at two levels. First, every store needs the write-enable latch, and every write command clears that latch. Second, a 2-bit block-protect field fences off an upper slice of the array. A separate active-low pin, `wp_n`, can freeze the status byte. The pin only acts when the status enable bit is set, and it never blocks the array. Writes complete at once, so the block is never busy.

The SPI pins are sampled in the `clk` domain. They must reach the block already synchronous to `clk`, and each SCK phase must last at least 3 `clk` cycles. The nonvolatile fields hold their value until reset.

Top module: `spi_wp_ctrl`

## Requirements
- R1: The status byte reads as {WPEN, 0, 0, 0, BP1, BP0, WEL, 0}, with WPEN at bit 7, BP1:BP0 at bits 3:2 and WEL at bit 1. Bits 0 and 6:4 always read 0, whatever is written to them.
- R2: After reset the status byte is 00h, so WEL, WPEN and BP are all 0.
- R3: Opcode 06h sets WEL when its eighth bit is received. Opcode 04h clears WEL.
- R4: Opcode 01h followed by one data byte copies data bit 7 to WPEN and data bits 3:2 to BP. The copy happens only when WEL = 1 and the pair (WPEN = 1, `wp_n` = 0) does not hold. Data bit 1 never changes WEL. WEL is 0 once the data byte completes.
- R5: When WPEN = 0, `wp_n` has no effect. `wp_n` never blocks an array write.
- R6: BP selects the protected range: 00 protects nothing, 01 protects 600h–7FFh, 10 protects 400h–7FFh and 11 protects 000h–7FFh.
- R7: Opcode 02h, a 2-byte address (high byte first), then data bytes. Each data byte is stored only when WEL = 1 and its own address is outside the protected range. A rejected byte leaves the array unchanged.
- R8: Opcode 03h, a 2-byte address, then bytes read out on MISO starting at that address. For both 02h and 03h, the top 5 address bits are ignored and the address steps by one per data byte, wrapping from 7FFh to 000h.
- R9: A 02h command clears WEL when chip-select rises, even if it carried no data or some of its bytes were rejected.
- R10: After opcode 05h, the next byte on MISO is the status byte. Any further bytes in the same select read 00h.
- R11: Raising chip-select part-way through a byte or a command discards that command. After an unknown opcode, every byte is ignored until chip-select rises.
- R12: MISO is 0 while chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all SPI pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_miso | output | 1 | Serial data out, MSB first, 0 when deselected |
| wp_n | input | 1 | Status-byte write-protect pin, active low |

## Verification
The bound checker checks the write rules on every cycle:
- no array store without WEL or inside the range that BP selects;
- no status change while WEL is 0, or while WPEN is 1 and `wp_n` is low;
- WEL rises only right after a completed 06h opcode;
- no store and a quiet MISO while deselected.

Some behaviour shows only as a sequence of bytes, and only the bench's scenarios can show it:
- address wrap and the ignored upper address bits;
- the exact byte order on MISO;
- WEL cleared at deselect after a write command;
- aborted partial bytes;
- unknown opcodes.

The bench sweeps all four BP settings over boundary and strided addresses, with `wp_n` held low, and compares against an arithmetic model.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OP_SET_WEL = 8'h06;
   localparam logic [BYTE_W-1:0] OP_CLR_WEL = 8'h04;
   localparam logic [BYTE_W-1:0] OP_RD_STAT = 8'h05;
   localparam logic [BYTE_W-1:0] OP_WR_STAT = 8'h01;
   localparam logic [BYTE_W-1:0] OP_RD_MEM  = 8'h03;
   localparam logic [BYTE_W-1:0] OP_WR_MEM  = 8'h02;

   typedef enum logic [2:0] {
      CS_OPCODE,
      CS_ADDR,
      CS_RD_DATA,
      CS_WR_DATA,
      CS_STAT_WR,
      CS_STAT_RD,
      CS_DISCARD
   } cmd_state_e;

   typedef enum logic [1:0] {
      TX_ZERO,
      TX_STAT,
      TX_RAM
   } tx_src_e;

   function automatic logic [BYTE_W-1:0] pack_status(logic en_pin, logic [1:0] blk, logic latch);
      return {en_pin, 3'b000, blk, latch, 1'b0};
   endfunction
endpackage

// File: rtl/spi_wp_shifter.sv
module spi_wp_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn,
   input  logic              sck,
   input  logic              mosi,
   input  logic              tx_load,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              rx_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              cs_rise,
   output logic              miso
);
   localparam int CNT_W = $clog2(BYTE_W);

   if (BYTE_W < 2) begin : g_bad_width
      $error("spi_wp_shifter: BYTE_W must be at least 2");
   end

   logic              sck_q;
   logic              csn_q;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;

   logic sck_up;
   logic sck_dn;
   logic last_bit;

   assign sck_up   = sck & ~sck_q & ~csn;
   assign sck_dn   = ~sck & sck_q & ~csn;
   assign last_bit = (bit_cnt == CNT_W'(BYTE_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         csn_q   <= 1'b1;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
      end else begin
         sck_q <= sck;
         csn_q <= csn;
         if (csn) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
         end else begin
            if (sck_up) begin
               rx_sh   <= {rx_sh[BYTE_W-2:0], mosi};
               bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
            end
            if (tx_load) begin
               tx_sh <= tx_byte;
            end else if (sck_dn && bit_cnt != '0) begin
               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign rx_done = sck_up & last_bit;
   assign rx_byte = {rx_sh[BYTE_W-2:0], mosi};
   assign cs_rise = csn & ~csn_q;
   assign miso    = ~csn & tx_sh[BYTE_W-1];
endmodule

// File: rtl/spi_wp_guard.sv
module spi_wp_guard #(
   parameter int ADDR_W = 11
) (
   input  logic [1:0]        blk,
   input  logic [ADDR_W-1:0] addr,
   output logic              fenced
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("spi_wp_guard: ADDR_W must be at least 2");
   end

   always_comb begin
      unique case (blk)
         2'b00:   fenced = 1'b0;
         2'b01:   fenced = &addr[ADDR_W-1 -: 2];
         2'b10:   fenced = addr[ADDR_W-1];
         default: fenced = 1'b1;
      endcase
   end
endmodule

// File: rtl/spi_wp_ram.sv
module spi_wp_ram #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W > 12) begin : g_too_deep
      $error("spi_wp_ram: ADDR_W above 12 exceeds the modelled array size");
   end

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[addr] <= wdata;
      end
      rdata <= cells[addr];
   end
endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl
   import spi_wp_pkg::*;
#(
   parameter int ADDR_W     = 11,
   parameter int CMD_ADDR_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_csn,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso,
   input  logic wp_n
);
   localparam int ADDR_BYTES = CMD_ADDR_W / BYTE_W;
   localparam int AB_W       = $clog2(ADDR_BYTES + 1);

   if (CMD_ADDR_W % BYTE_W != 0 || CMD_ADDR_W < ADDR_W) begin : g_bad_cfg
      $error("spi_wp_ctrl: CMD_ADDR_W must be whole bytes and cover ADDR_W");
   end

   cmd_state_e        state;
   tx_src_e           tx_src;
   logic [AB_W-1:0]   ab_cnt;
   logic [ADDR_W-1:0] addr_acc;
   logic [ADDR_W-1:0] ptr;
   logic              wel;
   logic              wpen;
   logic [1:0]        bp;
   logic              wr_cmd;
   logic [1:0]        ld_q;

   logic              rx_done;
   logic [BYTE_W-1:0] rx_byte;
   logic              cs_rise;
   logic [BYTE_W-1:0] tx_byte;
   logic [BYTE_W-1:0] ram_rdata;
   logic              fenced;
   logic              mem_we;
   logic              in_opcode;
   logic              stat_open;

   spi_wp_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .csn     (spi_csn),
      .sck     (spi_sck),
      .mosi    (spi_mosi),
      .tx_load (ld_q[1]),
      .tx_byte (tx_byte),
      .rx_done (rx_done),
      .rx_byte (rx_byte),
      .cs_rise (cs_rise),
      .miso    (spi_miso)
   );

   spi_wp_guard #(.ADDR_W(ADDR_W)) u_guard (
      .blk    (bp),
      .addr   (ptr),
      .fenced (fenced)
   );

   spi_wp_ram #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
      .clk   (clk),
      .we    (mem_we),
      .addr  (ptr),
      .wdata (rx_byte),
      .rdata (ram_rdata)
   );

   assign in_opcode = (state == CS_OPCODE);
   assign stat_open = ~(wpen & ~wp_n);
   assign mem_we    = rx_done & (state == CS_WR_DATA) & wel & ~fenced;

   always_comb begin
      unique case (tx_src)
         TX_STAT: tx_byte = pack_status(wpen, bp, wel);
         TX_RAM:  tx_byte = ram_rdata;
         default: tx_byte = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= CS_OPCODE;
         tx_src   <= TX_ZERO;
         ab_cnt   <= '0;
         addr_acc <= '0;
         ptr      <= '0;
         wel      <= 1'b0;
         wpen     <= 1'b0;
         bp       <= 2'b00;
         wr_cmd   <= 1'b0;
         ld_q     <= 2'b00;
      end else begin
         ld_q <= {ld_q[0], rx_done};
         if (cs_rise && wr_cmd) begin
            wel <= 1'b0;
         end
         if (spi_csn) begin
            state  <= CS_OPCODE;
            ab_cnt <= '0;
            wr_cmd <= 1'b0;
         end else if (rx_done) begin
            tx_src <= TX_ZERO;
            unique case (state)
               CS_OPCODE: begin
                  unique case (rx_byte)
                     OP_SET_WEL: begin wel <= 1'b1; state <= CS_DISCARD; end
                     OP_CLR_WEL: begin wel <= 1'b0; state <= CS_DISCARD; end
                     OP_RD_STAT: begin tx_src <= TX_STAT; state <= CS_STAT_RD; end
                     OP_WR_STAT: state <= CS_STAT_WR;
                     OP_RD_MEM:  state <= CS_ADDR;
                     OP_WR_MEM:  begin wr_cmd <= 1'b1; state <= CS_ADDR; end
                     default:    state <= CS_DISCARD;
                  endcase
               end
               CS_ADDR: begin
                  addr_acc <= ADDR_W'({addr_acc, rx_byte});
                  if (ab_cnt == AB_W'(ADDR_BYTES - 1)) begin
                     ptr    <= ADDR_W'({addr_acc, rx_byte});
                     ab_cnt <= '0;
                     state  <= wr_cmd ? CS_WR_DATA : CS_RD_DATA;
                     tx_src <= wr_cmd ? TX_ZERO : TX_RAM;
                  end else begin
                     ab_cnt <= ab_cnt + 1'b1;
                  end
               end
               CS_RD_DATA: begin
                  ptr    <= ptr + 1'b1;
                  tx_src <= TX_RAM;
               end
               CS_WR_DATA: ptr <= ptr + 1'b1;
               CS_STAT_WR: begin
                  if (wel && stat_open) begin
                     wpen <= rx_byte[7];
                     bp   <= rx_byte[3:2];
                  end
                  wel   <= 1'b0;
                  state <= CS_DISCARD;
               end
               default: state <= CS_DISCARD;
            endcase
         end
      end
   end
endmodule

// File: rtl/spi_wp_checker.sv
module spi_wp_checker #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              spi_csn,
   input logic              spi_miso,
   input logic              wp_n,
   input logic              wel,
   input logic              wpen,
   input logic [1:0]        bp,
   input logic              mem_we,
   input logic [ADDR_W-1:0] ptr,
   input logic              rx_done,
   input logic [7:0]        rx_byte,
   input logic              in_opcode
);
   localparam int DEPTH = 1 << ADDR_W;

   AST_ARRAY_WR_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wel);  // R7

   AST_ARRAY_WR_OUTSIDE_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !((bp == 2'd3) || (bp == 2'd2 && int'(ptr) >= DEPTH / 2)
                   || (bp == 2'd1 && int'(ptr) >= (DEPTH / 4) * 3)));  // R6

   AST_STAT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      !wel |=> $stable({wpen, bp}));  // R4

   AST_STAT_PIN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (wpen && !wp_n) |=> $stable({wpen, bp}));  // R4

   AST_WEL_RISES_ON_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(rx_done && in_opcode && rx_byte == 8'h06));  // R3

   AST_NO_STORE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      spi_csn |-> !mem_we);  // R11

   AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      spi_csn |-> !spi_miso);  // R12
endmodule

bind spi_wp_ctrl spi_wp_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .spi_csn   (spi_csn),
   .spi_miso  (spi_miso),
   .wp_n      (wp_n),
   .wel       (wel),
   .wpen      (wpen),
   .bp        (bp),
   .mem_we    (mem_we),
   .ptr       (ptr),
   .rx_done   (rx_done),
   .rx_byte   (rx_byte),
   .in_opcode (in_opcode)
);

// File: tb/test_spi_wp_ctrl.sv
module test_spi_wp_ctrl;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_csn = 1'b1;
   logic spi_sck = 1'b0;
   logic spi_mosi = 1'b0;
   logic wp_n = 1'b1;
   logic spi_miso;

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0] model [2048];
   logic [1:0] cur_bp = 2'b00;

   always #5 clk = ~clk;

   spi_wp_ctrl i_spi_wp_ctrl (
      .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .wp_n(wp_n)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit fenced(input logic [1:0] b, input int a);
      case (b)
         2'd0: return 1'b0;
         2'd1: return a >= 'h600;
         2'd2: return a >= 'h400;
         default: return 1'b1;
      endcase
   endfunction

   task automatic one_bit(input logic b, output logic r);
      spi_mosi = b;
      repeat (HALF) @(negedge clk);
      r = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
   endtask

   task automatic xfer(input logic [7:0] d, output logic [7:0] r);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         one_bit(d[i], b);
         r[i] = b;
      end
   endtask

   task automatic sel();
      spi_csn = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic desel();
      repeat (HALF) @(negedge clk);
      spi_csn = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] r;
      sel(); xfer(op, r); desel();
   endtask

   task automatic rd_stat(output logic [7:0] s);
      logic [7:0] r;
      sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
   endtask

   task automatic wr_stat(input logic [7:0] v);
      logic [7:0] r;
      sel(); xfer(8'h01, r); xfer(v, r); desel();
   endtask

   task automatic mem_wr(input logic [15:0] a, input logic [7:0] d [4], input int n, input bit wel_on);
      logic [7:0] r;
      sel(); xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r);
      for (int i = 0; i < n; i++) begin
         xfer(d[i], r);
         if (wel_on && !fenced(cur_bp, (int'(a) + i) % 2048))
            model[(int'(a) + i) % 2048] = d[i];
      end
      desel();
   endtask

   task automatic mem_rd_chk(input string req, input logic [15:0] a, input int n);
      logic [7:0] r;
      sel(); xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r);
      for (int i = 0; i < n; i++) begin
         xfer(8'h00, r);
         check(req, r, model[(int'(a) + i) % 2048]);
      end
      desel();
   endtask

   function automatic int sweep_addr(input int k);
      case (k)
         0: return 'h000;
         1: return 'h3FF;
         2: return 'h400;
         3: return 'h5FF;
         4: return 'h600;
         5: return 'h7FF;
         default: return (k - 6) * 256 + 37;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] s;
      logic [7:0] s2;
      logic [7:0] r;
      logic [7:0] d [4];
      for (int i = 0; i < 2048; i++) model[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      check("R12 miso idle", {7'd0, spi_miso}, 8'h00);
      rd_stat(s); check("R2 R1 reset status", s, 8'h00);

      cmd1(8'h06);
      sel(); xfer(8'h05, r); xfer(8'h00, s); xfer(8'h00, s2); desel();
      check("R3 R1 status after set-WEL", s, 8'h02);
      check("R10 trailing status byte", s2, 8'h00);
      cmd1(8'h04); rd_stat(s); check("R3 WEL cleared", s, 8'h00);

      wr_stat(8'hFF); rd_stat(s); check("R4 status write without WEL", s, 8'h00);
      cmd1(8'h06); wr_stat(8'hFF); rd_stat(s); check("R4 R1 status write masked", s, 8'h8C);

      wp_n = 1'b0;
      cmd1(8'h06); wr_stat(8'h00); rd_stat(s); check("R4 pin blocks status", s, 8'h8C);
      wp_n = 1'b1;
      cmd1(8'h06); wr_stat(8'h00); rd_stat(s); check("R4 pin released", s, 8'h00);
      wp_n = 1'b0;
      cmd1(8'h06); wr_stat(8'h0C); rd_stat(s); check("R5 pin ignored when WPEN=0", s, 8'h0C);
      cmd1(8'h06); wr_stat(8'h00); rd_stat(s); check("R5 pin ignored again", s, 8'h00);
      wp_n = 1'b1;
      check("R12 miso idle between", {7'd0, spi_miso}, 8'h00);

      sel(); for (int i = 7; i >= 1; i--) one_bit(r[0] ^ r[0] ^ 8'h06 >> i & 1'b1, r[1]); desel();
      rd_stat(s); check("R11 partial set-WEL opcode", s, 8'h00);
      cmd1(8'h06);
      sel(); xfer(8'h01, r); for (int i = 0; i < 5; i++) one_bit(1'b1, r[0]); desel();
      rd_stat(s); check("R11 partial status write", s, 8'h02);
      cmd1(8'h04);

      cur_bp = 2'b00;
      for (int k = 0; k < 14; k++) begin
         d[0] = 8'(sweep_addr(k)) ^ 8'h5A;
         cmd1(8'h06); mem_wr(16'(sweep_addr(k)), d, 1, 1'b1);
      end

      for (int bv = 1; bv <= 4; bv++) begin
         cmd1(8'h06); wr_stat(8'h80 | 8'((bv % 4) << 2));
         cur_bp = 2'(bv % 4);
         rd_stat(s); check("R1 R4 sweep status", s, 8'h80 | 8'((bv % 4) << 2));
         wp_n = 1'b0;
         for (int k = 0; k < 14; k++) begin
            d[0] = 8'(sweep_addr(k) * 3 + bv * 17 + 1);
            cmd1(8'h06); mem_wr(16'(sweep_addr(k)), d, 1, 1'b1);
            mem_rd_chk("R6 R7 R5 sweep readback", 16'(sweep_addr(k)), 1);
         end
         wp_n = 1'b1;
      end
      cmd1(8'h06); wr_stat(8'h00); cur_bp = 2'b00;
      rd_stat(s); check("R4 sweep cleanup", s, 8'h00);

      d = '{8'h11, 8'h22, 8'h33, 8'h44};
      cmd1(8'h06); mem_wr(16'hF7FE, d, 4, 1'b1);
      mem_rd_chk("R8 wrap readback", 16'h07FE, 4);
      mem_rd_chk("R8 upper bits ignored", 16'h8000, 2);

      cmd1(8'h06);
      sel(); xfer(8'hAB, r); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h99, r); desel();
      rd_stat(s); check("R11 unknown opcode keeps WEL", s, 8'h02);
      mem_rd_chk("R11 unknown opcode no store", 16'h0000, 1);
      cmd1(8'h04);

      d = '{8'hE1, 8'hE2, 8'hE3, 8'hE4};
      mem_wr(16'h0000, d, 2, 1'b0);
      mem_rd_chk("R7 no store without WEL", 16'h0000, 2);

      cmd1(8'h06); wr_stat(8'h04); cur_bp = 2'b01;
      d = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
      cmd1(8'h06); mem_wr(16'h05FD, d, 4, 1'b1);
      rd_stat(s); check("R9 WEL cleared after write", s, 8'h04);
      mem_rd_chk("R7 R6 burst across fence", 16'h05FD, 4);

      cmd1(8'h06);
      sel(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h10, r); desel();
      rd_stat(s); check("R9 empty write clears WEL", s, 8'h04);
      check("R12 miso idle at end", {7'd0, spi_miso}, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule